// File: doc/BRIEF.md
# Multiplexer Logic Module

This block is a configurable combinational logic cell made of three two-to-one multiplexers and an OR gate. Two first-level multiplexers each produce a wheel output. A third multiplexer picks between those two wheel outputs. Its select is the OR of two select pins. Each of the eight configurable pins takes a constant 0, a constant 1 or one of the external signal inputs, so one cell can realise any two-input Boolean function and many wider ones.

The configuration is held in a register that loads one bit per clock through a serial shift chain while a load enable is high. The logic output is purely combinational from the stored configuration and the signal inputs. A storage element such as a transparent latch is formed by wiring the output back to one of the signal inputs outside the cell.

Top module: `mux_logic_module`

## Requirements
- R1: A synchronous active-low reset clears the whole configuration register. After reset every pin selects constant 0, so `y` is 0 for any `sig_in`.
- R2: While `cfg_en` is high, each rising clock edge shifts `cfg_bit` into the top bit of the configuration register and moves every bit down by one, so the first bit sent ends at bit 0. While `cfg_en` is low the configuration holds, whatever `cfg_bit` does.
- R3: Each pin has a code of CODE_W = clog2(NUM_IN+2) bits. Code 0 selects constant 0 and code 1 selects constant 1. Code 2+k selects `sig_in[k]`: A=2, B=3, C=4 and D=5 with NUM_IN=4. Any code above NUM_IN+1 selects constant 0.
- R4: Pin p occupies register bits [p*CODE_W +: CODE_W]. The pins in order p=0..7 are: wheel 1 data0, wheel 1 data1, wheel 1 select, wheel 2 data0, wheel 2 data1, wheel 2 select, output select S0 and output select S1.
- R5: Each wheel outputs data1 when its select is 1 and data0 otherwise. `y` equals wheel 2 when (S0 OR S1) is 1 and wheel 1 otherwise.
- R6: `y` depends combinationally on `sig_in` and the configuration. An input change shows on `y` in the same cycle, with no clock edge.
- R7: For each of the 16 truth tables of two inputs A and B there is a configuration that makes `y` match that table for all four input pairs.
- R8: NAND(A,B) is produced by wheel 1 = 1 (constant 1 on both data pins), wheel 2 = NOT B (data0 = 1, data1 = 0, select = B), S0 = A and S1 = 0.
- R9: (A·B)+(B'·C)+D is produced by wheel 1 = C ? 1 : D, wheel 2 = A ? 1 : D, S0 = B and S1 = 0.
- R10: With wheel 1 = B ? A : C, S0 = S1 = 0 and `y` fed back to C, the cell acts as a transparent latch. `y` follows A while B is 1 and holds its value while B is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Synchronous active-low reset, clears the configuration |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_bit | input | 1 | Serial configuration data, lowest bit first |
| sig_in | input | NUM_IN | External signal inputs A, B, C, D in bit order 0 upward |
| y | output | 1 | Logic module output |

## Verification
A new configuration bit takes effect at the rising edge that shifts it in. The output therefore reflects a loaded configuration in the cycle after the edge carrying the last bit. A change on the signal inputs shows on `y` at once, within the same cycle. The bench drives inputs on the falling edge and samples `y` one nanosecond later, so each explicit check sees a settled combinational result. A behavioural model of the shift chain is updated at every rising edge and compared with `y` two nanoseconds after that edge, which is well before the next input change.

// File: rtl/mlm_pkg.sv
// Package mlm_pkg
// Shared definitions for the multiplexer logic module: pin numbering and
// the width of one pin code for a given number of signal inputs.
package mlm_pkg;

    // Configurable pins, in register order (pin p sits at bits p*CODE_W).
    typedef enum int {
        PIN_W1_D0  = 0,
        PIN_W1_D1  = 1,
        PIN_W1_SEL = 2,
        PIN_W2_D0  = 3,
        PIN_W2_D1  = 4,
        PIN_W2_SEL = 5,
        PIN_S0     = 6,
        PIN_S1     = 7
    } pin_e;

    localparam int NUM_PINS = 8;

    // Code values for the two constant sources; inputs start at SRC_IN0.
    localparam int SRC_ZERO = 0;
    localparam int SRC_ONE  = 1;
    localparam int SRC_IN0  = 2;

    // Bits needed to encode two constants plus n inputs.
    function automatic int code_width(input int n);
        return $clog2(n + 2);
    endfunction

endpackage

// File: rtl/mlm_cfg_chain.sv
// Module mlm_cfg_chain
// Serial configuration register. While en is high, each clock shifts
// din into the top bit and moves the rest down, so the first bit sent
// lands at bit 0 after WIDTH shifts. Assumes a synchronous active-low reset.
module mlm_cfg_chain #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             din,
    output logic [WIDTH-1:0] cfg
);

    // Shift register update: clear on reset, shift when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (en) begin
            cfg <= {din, cfg[WIDTH-1:1]};
        end
    end

    // R2: configuration is frozen while the enable is low.
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && $past(rst_n)) |=> $stable(cfg));

    // R2: the newest serial bit appears at the top of the register.
    a_r2_bit_enters_top: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> cfg[WIDTH-1] == $past(din));

endmodule

// File: rtl/mlm_pin_source.sv
// Module mlm_pin_source
// Source selector for one configurable pin. It decodes a pin code into
// constant 0, constant 1 or one of the signal inputs. Codes past the last
// input give constant 0. Purely combinational.
module mlm_pin_source
    import mlm_pkg::*;
#(
    parameter int NUM_IN = 4,
    parameter int CODE_W = 3
) (
    input  logic [CODE_W-1:0] code,
    input  logic [NUM_IN-1:0] sig_in,
    output logic              val
);

    // Decode the pin code into its selected source value.
    always_comb begin
        val = 1'b0;
        if (code == CODE_W'(SRC_ONE)) begin
            val = 1'b1;
        end
        for (int k = 0; k < NUM_IN; k++) begin
            if (code == CODE_W'(SRC_IN0 + k)) begin
                val = sig_in[k];
            end
        end
    end

    // R3: the constant codes produce their constants.
    always_comb begin
        if (code == CODE_W'(SRC_ZERO)) begin
            a_r3_code_zero: assert (val == 1'b0);
        end
        if (code == CODE_W'(SRC_ONE)) begin
            a_r3_code_one: assert (val == 1'b1);
        end
    end

endmodule

// File: rtl/mlm_mux2.sv
// Module mlm_mux2
// Two-to-one multiplexer: passes d1 when s is 1 and d0 otherwise.
module mlm_mux2 (
    input  logic d0,
    input  logic d1,
    input  logic s,
    output logic y
);

    // Select between the two data inputs.
    always_comb begin
        y = s ? d1 : d0;
    end

endmodule

// File: rtl/mux_logic_module.sv
// Module mux_logic_module
// Configurable logic cell. Eight pin selectors feed two first-level
// multiplexers (the wheels) and an output multiplexer steered by S0 OR S1.
// The configuration loads serially. The output is combinational from the
// configuration and sig_in. Assumes a synchronous active-low reset.
module mux_logic_module
    import mlm_pkg::*;
#(
    parameter int NUM_IN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_bit,
    input  logic [NUM_IN-1:0] sig_in,
    output logic              y
);

    localparam int CODE_W = code_width(NUM_IN);
    localparam int CFG_W  = NUM_PINS * CODE_W;

    logic [CFG_W-1:0]    cfg_q;
    logic [NUM_PINS-1:0] pin_val;
    logic                wheel1;
    logic                wheel2;
    logic                out_sel;

    // Serial configuration storage.
    mlm_cfg_chain #(.WIDTH(CFG_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cfg_en),
        .din   (cfg_bit),
        .cfg   (cfg_q)
    );

    // One source selector per configurable pin.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        mlm_pin_source #(.NUM_IN(NUM_IN), .CODE_W(CODE_W)) u_src (
            .code   (cfg_q[p*CODE_W +: CODE_W]),
            .sig_in (sig_in),
            .val    (pin_val[p])
        );
    end

    mlm_mux2 u_wheel1 (
        .d0 (pin_val[PIN_W1_D0]),
        .d1 (pin_val[PIN_W1_D1]),
        .s  (pin_val[PIN_W1_SEL]),
        .y  (wheel1)
    );

    mlm_mux2 u_wheel2 (
        .d0 (pin_val[PIN_W2_D0]),
        .d1 (pin_val[PIN_W2_D1]),
        .s  (pin_val[PIN_W2_SEL]),
        .y  (wheel2)
    );

    // Output select is the OR of the two select pins.
    always_comb begin
        out_sel = pin_val[PIN_S0] | pin_val[PIN_S1];
    end

    mlm_mux2 u_out (
        .d0 (wheel1),
        .d1 (wheel2),
        .s  (out_sel),
        .y  (y)
    );

    // R5: with both output selects low, the cell output follows wheel 1.
    a_r5_low_sel_wheel1: assert property (@(posedge clk) disable iff (!rst_n)
        !(pin_val[PIN_S0] || pin_val[PIN_S1]) |-> (y == wheel1));

    // R5: with either output select high, the cell output follows wheel 2.
    a_r5_high_sel_wheel2: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_val[PIN_S0] || pin_val[PIN_S1]) |-> (y == wheel2));

    // R6: no change of configuration or inputs means no change of output.
    a_r6_output_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(cfg_q) && $stable(sig_in)) |-> $stable(y));

endmodule

// File: tb/mux_logic_module_bench.sv
module mux_logic_module_bench;

    localparam int NI = 4;
    localparam int CW = 3;
    localparam int NP = 8;
    localparam int W  = NP * CW;

    localparam int C0 = 0, C1 = 1, SA = 2, SB = 3, SC = 4, SD = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b0;
    logic          cfg_bit = 1'b0;
    logic [NI-1:0] sig_in = '0;
    logic          y;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit model_on = 0;
    int pc [NP];

    bit mq [$];

    mux_logic_module #(.NUM_IN(NI)) u_mux_logic_module (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_en  (cfg_en),
        .cfg_bit (cfg_bit),
        .sig_in  (sig_in),
        .y       (y)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: queue of configuration bits, index = bit number.
    function automatic bit src_val(input int p);
        int code = 0;
        for (int j = 0; j < CW; j++) code += int'(mq[p*CW + j]) << j;
        if (code == 1) return 1'b1;
        if (code >= 2 && code < 2 + NI) return sig_in[code-2];
        return 1'b0;
    endfunction

    function automatic bit model_y();
        bit w1, w2;
        w1 = src_val(2) ? src_val(1) : src_val(0);
        w2 = src_val(5) ? src_val(4) : src_val(3);
        if (src_val(6) || src_val(7)) return w2;
        return w1;
    endfunction

    // Model update at every edge, comparison two ns later (R5, R2).
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            for (int i = 0; i < W; i++) mq.push_back(1'b0);
        end else if (cfg_en && mq.size() == W) begin
            mq.push_back(cfg_bit);
            void'(mq.pop_front());
        end
        #2;
        if (model_on && rst_n) chk("R5 per-clock model", y, model_y());
    end

    // Shift the pin codes in pc[] through the chain, lowest bit first.
    task automatic load_pins();
        logic [W-1:0] v;
        for (int p = 0; p < NP; p++) v[p*CW +: CW] = CW'(pc[p]);
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            cfg_en  = 1'b1;
            cfg_bit = v[i];
        end
        @(negedge clk);
        cfg_en = 1'b0;
    endtask

    task automatic set_pins(input int a0, a1, as, b0, b1, bs, s0, s1);
        pc[0] = a0; pc[1] = a1; pc[2] = as;
        pc[3] = b0; pc[4] = b1; pc[5] = bs;
        pc[6] = s0; pc[7] = s1;
    endtask

    task automatic apply(input logic [NI-1:0] v);
        @(negedge clk);
        sig_in = v;
        #1;
    endtask

    // Close the latch loop: copy y onto C until it settles.
    task automatic settle_latch();
        for (int i = 0; i < 3; i++) begin
            sig_in[2] = y;
            #1;
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        sig_in = 4'b1111;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_on = 1;
        #1;
        // R1: cleared configuration gives 0 even with all inputs high.
        chk("R1 reset output", y, 1'b0);
        apply(4'b1010);
        chk("R1 reset output alt inputs", y, 1'b0);

        // R8: NAND through wheel2 = NOT B, S0 = A.
        set_pins(C1, C1, C0, C1, C0, SB, SA, C0);
        load_pins();
        for (int v = 0; v < 4; v++) begin
            apply(NI'(v));
            chk("R8 nand", y, ~(v[0] & v[1]));
        end

        // R2: enable low, toggling serial data must not alter the function.
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            cfg_bit = i[0];
        end
        for (int v = 0; v < 4; v++) begin
            apply(NI'(v));
            chk("R2 hold with enable low", y, ~(v[0] & v[1]));
        end

        // R6: input change visible in the same cycle, no clock edge between.
        @(negedge clk);
        sig_in = 4'b0011;
        #1;
        chk("R6 combinational a", y, 1'b0);
        sig_in = 4'b0001;
        #1;
        chk("R6 combinational b", y, 1'b1);

        // R7: every two-input truth table, indexed tt[{a,b}].
        for (int tt = 0; tt < 16; tt++) begin
            set_pins(tt[0], tt[1], SB, tt[2], tt[3], SB, SA, C0);
            load_pins();
            for (int v = 0; v < 4; v++) begin
                apply(NI'(v));
                chk($sformatf("R7 table %0d", tt), y, tt[{v[0], v[1]}]);
            end
        end

        // R4 and R5: select via S1 alone; wheel 2 = D, wheel 1 = C.
        set_pins(SC, SC, C0, SD, SD, C0, C0, SA);
        load_pins();
        apply(4'b0100);
        chk("R4 S1 low picks wheel1", y, 1'b1);
        apply(4'b0101);
        chk("R4 S1 high picks wheel2", y, 1'b0);
        apply(4'b1001);
        chk("R5 S1 high wheel2 D", y, 1'b1);

        // R3: each input code routes that input; out-of-range codes give 0.
        for (int k = 0; k < NI; k++) begin
            set_pins(SA + k, C0, C0, C0, C0, C0, C0, C0);
            load_pins();
            apply(NI'(1 << k));
            chk($sformatf("R3 input code %0d high", SA + k), y, 1'b1);
            apply(~NI'(1 << k));
            chk($sformatf("R3 input code %0d low", SA + k), y, 1'b0);
        end
        set_pins(6, C0, C0, C0, C0, C0, C0, C0);
        load_pins();
        apply(4'b1111);
        chk("R3 code 6 is zero", y, 1'b0);
        set_pins(7, C0, C0, C0, C0, C0, C0, C0);
        load_pins();
        apply(4'b1111);
        chk("R3 code 7 is zero", y, 1'b0);

        // R9: (A&B) | (~B&C) | D over all 16 input patterns.
        set_pins(SD, C1, SC, SD, C1, SA, SB, C0);
        load_pins();
        for (int v = 0; v < 16; v++) begin
            apply(NI'(v));
            chk("R9 four input function", y,
                (v[0] & v[1]) | (~v[1] & v[2]) | v[3]);
        end

        // R10: latch, data A, enable B, feedback on C.
        set_pins(SC, SA, SB, C0, C0, C0, C0, C0);
        load_pins();
        @(negedge clk);
        sig_in = 4'b0011; settle_latch();
        chk("R10 latch transparent 1", y, 1'b1);
        sig_in[1] = 1'b0; settle_latch();
        sig_in[0] = 1'b0; settle_latch();
        chk("R10 latch holds 1", y, 1'b1);
        @(negedge clk);
        sig_in[1] = 1'b1; settle_latch();
        chk("R10 latch transparent 0", y, 1'b0);
        sig_in[1] = 1'b0; settle_latch();
        sig_in[0] = 1'b1; settle_latch();
        chk("R10 latch holds 0", y, 1'b0);

        // R1: reset again clears a loaded configuration.
        set_pins(C1, C1, C0, C1, C1, C0, C0, C0);
        load_pins();
        apply(4'b0000);
        chk("R1 constant one before reset", y, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 cleared after reset", y, 1'b0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule